// File: doc/BRIEF.md
# Run-time configurable Reed-Solomon parity encoder

This block turns a stream of byte symbols into a systematic Reed-Solomon codeword over GF(2^8). Each message symbol is copied to the output one cycle later and also fed into a division register of up to 32 byte stages. When the host raises the parity-enable input, the remainder of x^2T·I(x) divided by G(x) is shifted out, highest-degree symbol first. At that point the register has drained and the next block can follow at once.

The generator polynomial is chosen at run time. With the configuration select high, a configuration code either picks one of sixteen built-in generators, whose roots are alpha^1 through alpha^2T for 2T = 2, 4, … 32, or writes the data byte into one generator coefficient. This lets a single register chain serve every redundancy level, including generators with other root offsets. Shortened codes need no special handling because leading zero symbols leave the remainder unchanged.

Top module: `rs_flex_encoder`

## Requirements
- R1: Field arithmetic uses x^8+x^4+x^3+x^2+1 (0x11D) with alpha = 0x02. The built-in generator for 2T=8, fed 02 03 83 93 9F 9F, yields the parity E7 38 1D F8 41 64 CD 6A.
- R2: With cfg_sel and par_en both low, dout equals the din value of the previous cycle (message pass-through, one register of latency).
- R3: With par_en high and cfg_sel low for 2T consecutive cycles, dout presents the 2T remainder symbols of x^2T·I(x) mod G(x), highest degree first, each one cycle after its enabling edge. din is ignored during these cycles.
- R4: After a synchronous active-low reset, dout is 0x00, the parity stages are empty and the built-in generator with 2T=16 is selected.
- R5: With cfg_sel high, a code 0x80+k (k = 0..15) selects the built-in generator with roots alpha^1..alpha^2T, where 2T = 2(k+1).
- R6: With cfg_sel high, a code 0x01+j (j = 0..31) writes din into coefficient g(j). The leading coefficient g(2T) is fixed at 1, so code 0x21 and any coefficient with index 2T or above have no effect on the parity.
- R7: With cfg_sel high, codes outside 0x01..0x21 and 0x80..0x8F change nothing.
- R8: While cfg_sel is low, cfg_code has no effect: the generator and 2T stay as configured.
- R9: A cycle with cfg_sel high empties the parity stages and drives dout to 0x00 in the next cycle.
- R10: After the 2T parity cycles the stages are empty. A next block may start in the following cycle, and an extra parity-enable cycle outputs 0x00.
- R11: Zero symbols at the front of a message (shortened codes) leave the parity unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_sel | input | 1 | High: configuration cycle; low: encoding cycle |
| cfg_code | input | 8 | Configuration code (select built-in generator or write coefficient) |
| par_en | input | 1 | High: shift out one parity symbol this cycle |
| din | input | 8 | Message symbol, or coefficient value in configuration |
| dout | output | 8 | Registered message symbol or parity symbol |

## Verification
A reference vector with 2T=8 pins down the field and the output order. A table of pseudo-random messages across 2T values from 2 to 32 is compared with a long-division model. Because the blocks run back to back, this also tests that the stages drain. A generator loaded by coefficient writes with roots alpha^0..alpha^3 separates the write path from the built-in table. Junk writes above the active degree, invalid codes and codes changed during encoding show whether any of these leaks into the parity. Leading zeros, a configuration cycle in the middle of a block and an extra parity cycle show whether the stages are cleared and drained correctly.

// File: rtl/rs_enc_pkg.sv
// Shared constants, symbol type and GF(2^8) helpers for the configurable
// Reed-Solomon encoder. Assumes the field polynomial 0x11D and alpha = 0x02.
package rs_enc_pkg;
    localparam int          SYM_W      = 8;
    localparam logic [8:0]  FIELD_POLY = 9'h11D;
    localparam int          MAX_NSYM   = 32;
    localparam logic [7:0]  SEL_BASE   = 8'h80;

    typedef logic [SYM_W-1:0] sym_t;

    // GF(2^8) product by shift and conditional reduction.
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[SYM_W-1] ? ((sh << 1) ^ FIELD_POLY[SYM_W-1:0]) : (sh << 1);
        end
        return acc;
    endfunction

    // Low coefficients g(0..nsym-1) of prod (x + alpha^i), i = 1..nsym.
    function automatic logic [MAX_NSYM*SYM_W-1:0] gen_coefs(int nsym);
        sym_t c [0:MAX_NSYM];
        sym_t root;
        logic [MAX_NSYM*SYM_W-1:0] res;
        for (int j = 0; j <= MAX_NSYM; j++) c[j] = '0;
        c[0] = 8'h01;
        root = 8'h01;
        for (int i = 1; i <= nsym; i++) begin
            root = gf_mul(root, 8'h02);
            for (int j = i; j >= 1; j--) c[j] = c[j-1] ^ gf_mul(c[j], root);
            c[0] = gf_mul(c[0], root);
        end
        res = '0;
        for (int j = 0; j < MAX_NSYM; j++)
            if (j < nsym) res[j*SYM_W +: SYM_W] = c[j];
        return res;
    endfunction
endpackage

// File: rtl/rs_gen_cfg.sv
// Generator store: holds the active low-order generator coefficients and the
// active parity count 2T. The built-in table is computed at elaboration.
// Acts only while cfg_sel is high; assumes a monic generator.
module rs_gen_cfg
    import rs_enc_pkg::*;
#(
    parameter int MAX_NSYM = rs_enc_pkg::MAX_NSYM
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_sel,
    input  logic [7:0]                    cfg_code,
    input  sym_t                          din,
    output sym_t                          coef_o [MAX_NSYM],
    output logic [$clog2(MAX_NSYM+1)-1:0] nsym_o
);
    localparam int NGEN    = MAX_NSYM / 2;
    localparam int GI_W    = $clog2(NGEN);
    localparam int NW      = $clog2(MAX_NSYM+1);
    localparam int DEF_IDX = NGEN / 2 - 1;

    logic [MAX_NSYM*SYM_W-1:0] rom [NGEN];
    sym_t                      g_q [MAX_NSYM];
    logic [NW-1:0]             nsym_q;
    logic                      sel_hit;
    logic [GI_W-1:0]           sel_idx;

    // Built-in generator table, one computed row per redundancy level.
    for (genvar k = 0; k < NGEN; k++) begin : g_rom
        localparam logic [MAX_NSYM*SYM_W-1:0] ROW = gen_coefs(2 * (k + 1));
        assign rom[k] = ROW;
    end

    // Decode of the built-in selection range.
    assign sel_hit = (int'(cfg_code) >= int'(SEL_BASE)) &&
                     (int'(cfg_code) <  int'(SEL_BASE) + NGEN);
    assign sel_idx = cfg_code[GI_W-1:0];

    // Coefficient and level registers: reset default, selection or single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < MAX_NSYM; j++) g_q[j] <= rom[DEF_IDX][j*SYM_W +: SYM_W];
            nsym_q <= NW'(2 * (DEF_IDX + 1));
        end else if (cfg_sel) begin
            if (sel_hit) begin
                for (int j = 0; j < MAX_NSYM; j++) g_q[j] <= rom[sel_idx][j*SYM_W +: SYM_W];
                nsym_q <= NW'((int'(sel_idx) + 1) * 2);
            end else begin
                for (int j = 0; j < MAX_NSYM; j++)
                    if (int'(cfg_code) == j + 1) g_q[j] <= din;
            end
        end
    end

    assign coef_o = g_q;
    assign nsym_o = nsym_q;

    // R5: the active level is always an even count between 2 and MAX_NSYM.
    a_r5_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (nsym_q[0] == 1'b0) && (nsym_q >= NW'(2)) && (int'(nsym_q) <= MAX_NSYM));
    // R5: code 0x80 in configuration selects the smallest level.
    a_r5_select_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && cfg_code == SEL_BASE) |=> (nsym_q == NW'(2)));
    // R8: encoding cycles never alter level or coefficients.
    a_r8_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel |=> ($stable(nsym_q) && $stable(g_q[0]) && $stable(g_q[MAX_NSYM-1])));
endmodule

// File: rtl/rs_lfsr.sv
// Parity division register: MAX_NSYM byte stages, of which the low nsym_i take
// part. Encoding folds din into the remainder, parity mode shifts it out
// highest stage first and fills with zeros, configuration empties it.
module rs_lfsr
    import rs_enc_pkg::*;
#(
    parameter int MAX_NSYM = rs_enc_pkg::MAX_NSYM
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_sel,
    input  logic                          par_en,
    input  sym_t                          din,
    input  sym_t                          coef_i [MAX_NSYM],
    input  logic [$clog2(MAX_NSYM+1)-1:0] nsym_i,
    output sym_t                          top_o
);
    sym_t par_q [MAX_NSYM];
    sym_t nxt   [MAX_NSYM];
    sym_t top;
    sym_t fb;
    logic any_nz;

    // Pick the highest active stage as the output and feedback source.
    always_comb begin
        top = '0;
        for (int j = 0; j < MAX_NSYM; j++)
            if (j == int'(nsym_i) - 1) top = par_q[j];
    end

    assign fb    = din ^ top;
    assign top_o = top;

    // Per-stage next value: clear, shift, or shift with weighted feedback.
    for (genvar i = 0; i < MAX_NSYM; i++) begin : g_stage
        sym_t prod;
        sym_t prev;
        logic active;
        assign prod   = gf_mul(fb, coef_i[i]);
        assign active = (i < int'(nsym_i));
        if (i == 0) begin : g_first
            assign prev = '0;
        end else begin : g_rest
            assign prev = par_q[i-1];
        end
        assign nxt[i] = (cfg_sel || !active) ? '0 :
                        par_en               ? prev : (prev ^ prod);

        // R6: stages above the active degree stay empty.
        a_r6_idle_stage_empty: assert property (@(posedge clk) disable iff (!rst_n)
            (i >= int'(nsym_i)) |-> (par_q[i] == '0));
    end

    // Stage registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < MAX_NSYM; j++) par_q[j] <= '0;
        end else begin
            for (int j = 0; j < MAX_NSYM; j++) par_q[j] <= nxt[j];
        end
    end

    // Any stage still holding a symbol.
    always_comb begin
        any_nz = 1'b0;
        for (int j = 0; j < MAX_NSYM; j++) any_nz = any_nz | (|par_q[j]);
    end

    // R9: a configuration cycle leaves every stage empty.
    a_r9_cfg_empties: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |=> !any_nz);
    // R10: parity shifting feeds zeros into the lowest stage.
    a_r10_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (par_en && !cfg_sel) |=> (par_q[0] == '0));
endmodule

// File: rtl/rs_flex_encoder.sv
// Top of the run-time configurable Reed-Solomon encoder. Joins the generator
// store and the division register and registers the output byte: message
// pass-through, parity symbol, or zero during configuration.
module rs_flex_encoder
    import rs_enc_pkg::*;
#(
    parameter int MAX_NSYM = rs_enc_pkg::MAX_NSYM
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_code,
    input  logic       par_en,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    localparam int NW = $clog2(MAX_NSYM+1);

    sym_t          coef_w [MAX_NSYM];
    logic [NW-1:0] nsym_w;
    sym_t          top_w;
    sym_t          dout_q;

    rs_gen_cfg #(.MAX_NSYM(MAX_NSYM)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_sel  (cfg_sel),
        .cfg_code (cfg_code),
        .din      (din),
        .coef_o   (coef_w),
        .nsym_o   (nsym_w)
    );

    rs_lfsr #(.MAX_NSYM(MAX_NSYM)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_sel (cfg_sel),
        .par_en  (par_en),
        .din     (din),
        .coef_i  (coef_w),
        .nsym_i  (nsym_w),
        .top_o   (top_w)
    );

    // Output register: zero in configuration, parity or message otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout_q <= '0;
        else if (cfg_sel) dout_q <= '0;
        else if (par_en)  dout_q <= top_w;
        else              dout_q <= din;
    end

    assign dout = dout_q;

    // R2: message symbols appear unchanged one cycle later.
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sel && !par_en) |=> (dout == $past(din)));
    // R9: the output is quiet after a configuration cycle.
    a_r9_quiet_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |=> (dout == 8'h00));
endmodule

// File: tb/rs_flex_encoder_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module rs_flex_encoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_code = 8'h00;
    logic       par_en = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] gexp [0:255];
    int         glog [0:255];
    int         gg   [0:32];
    logic [7:0] msg  [0:299];
    logic [7:0] epar [0:31];

    // {select code, message length, seed}
    localparam logic [23:0] VEC [8] = '{
        {8'h80, 8'd20,  8'h11}, {8'h81, 8'd33,  8'h22},
        {8'h83, 8'd40,  8'h5A}, {8'h87, 8'd188, 8'h3C},
        {8'h8A, 8'd7,   8'h99}, {8'h8E, 8'd64,  8'h01},
        {8'h8F, 8'd200, 8'hE7}, {8'h85, 8'd1,   8'h42}};

    rs_flex_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_code(cfg_code),
        .par_en(par_en), .din(din), .dout(dout));

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mul(logic [7:0] a, logic [7:0] b);
        if (a == 0 || b == 0) return 8'h00;
        return gexp[(glog[a] + glog[b]) % 255];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Generator with roots alpha^m0 .. alpha^(m0+n-1), monic, into gg.
    task automatic make_gen(int n, int m0);
        for (int j = 0; j <= 32; j++) gg[j] = 0;
        gg[0] = 1;
        for (int i = 0; i < n; i++) begin
            logic [7:0] r;
            r = gexp[(m0 + i) % 255];
            for (int j = i + 1; j >= 1; j--) gg[j] = gg[j-1] ^ int'(mul(8'(gg[j]), r));
            gg[0] = int'(mul(8'(gg[0]), r));
        end
    endtask

    // Long division of msg[0..len-1] * x^n by gg; remainder into epar.
    task automatic model(int n, int len);
        logic [7:0] w [0:331];
        for (int i = 0; i < len + n; i++) w[i] = (i < len) ? msg[i] : 8'h00;
        for (int i = 0; i < len; i++) begin
            logic [7:0] f;
            f = w[i];
            for (int j = 1; j <= n; j++) w[i+j] = w[i+j] ^ mul(f, 8'(gg[n-j]));
        end
        for (int j = 0; j < n; j++) epar[j] = w[len+j];
    endtask

    task automatic fill(int len, int seed);
        for (int i = 0; i < len; i++) msg[i] = 8'((seed * 37 + i * 13 + i * i * 5) & 255);
    endtask

    task automatic config_cycle(logic [7:0] code, logic [7:0] val);
        cfg_sel = 1'b1; par_en = 1'b0; cfg_code = code; din = val;
        step();
        cfg_sel = 1'b0; cfg_code = 8'h00;
    endtask

    // Encode msg[0..len-1], then shift n parity symbols; enc_code is driven on
    // cfg_code while encoding.
    task automatic run_block(int n, int len, logic [7:0] enc_code, string req);
        int pt_bad = 0, pt_act = 0, pt_exp = 0;
        int pb = 0, pa = 0, pe = 0;
        for (int i = 0; i < len; i++) begin
            cfg_sel = 1'b0; par_en = 1'b0; cfg_code = enc_code; din = msg[i];
            step();
            if (dout != msg[i]) begin
                if (pt_bad == 0) begin pt_act = dout; pt_exp = msg[i]; end
                pt_bad++;
            end
        end
        check(pt_bad == 0, "R2", {req, " message pass-through"}, pt_act, pt_exp);
        for (int j = 0; j < n; j++) begin
            par_en = 1'b1; din = 8'hA5 ^ 8'(j);
            step();
            if (dout != epar[j]) begin
                if (pb == 0) begin pa = dout; pe = epar[j]; end
                pb++;
            end
        end
        par_en = 1'b0; cfg_code = 8'h00;
        check(pb == 0, req, "parity symbols (R3)", pa, pe);
    endtask

    initial begin
        gexp[0] = 8'h01;
        for (int i = 1; i < 256; i++)
            gexp[i] = gexp[i-1][7] ? ((gexp[i-1] << 1) ^ 8'h1D) : (gexp[i-1] << 1);
        for (int i = 0; i < 256; i++) glog[i] = 0;
        for (int i = 0; i < 255; i++) glog[gexp[i]] = i;

        // R4: reset state.
        @(negedge clk); @(negedge clk);
        check(dout == 8'h00, "R4", "dout in reset", dout, 0);
        rst_n = 1'b1;
        fill(30, 7); make_gen(16, 1); model(16, 30);
        run_block(16, 30, 8'h00, "R4 default 2T=16");

        // R1: reference vector, 2T=8.
        config_cycle(8'h83, 8'h00);
        msg[0] = 8'h02; msg[1] = 8'h03; msg[2] = 8'h83;
        msg[3] = 8'h93; msg[4] = 8'h9F; msg[5] = 8'h9F;
        epar[0] = 8'hE7; epar[1] = 8'h38; epar[2] = 8'h1D; epar[3] = 8'hF8;
        epar[4] = 8'h41; epar[5] = 8'h64; epar[6] = 8'hCD; epar[7] = 8'h6A;
        run_block(8, 6, 8'h00, "R1 reference");

        // R5, R10: vector table, blocks back to back after each selection.
        for (int v = 0; v < 8; v++) begin
            int n, len;
            n   = 2 * (int'(VEC[v][19:16]) + 1);
            len = int'(VEC[v][15:8]);
            config_cycle(VEC[v][23:16], 8'h00);
            fill(len, int'(VEC[v][7:0])); make_gen(n, 1); model(n, len);
            run_block(n, len, 8'h00, "R5 table");
            fill(9, v + 3); model(n, 9);
            run_block(n, 9, 8'h00, "R10 back-to-back");
        end

        // R10: extra parity cycle after drain gives zero.
        par_en = 1'b1; din = 8'h77;
        step();
        check(dout == 8'h00, "R10", "extra parity cycle", dout, 0);
        par_en = 1'b0;

        // R6: coefficient writes build a root-offset-0 generator for 2T=4.
        config_cycle(8'h81, 8'h00);
        make_gen(4, 0);
        for (int j = 0; j < 4; j++) config_cycle(8'(j + 1), 8'(gg[j]));
        config_cycle(8'h05, 8'hC3);
        config_cycle(8'h15, 8'h5C);
        config_cycle(8'h21, 8'h99);
        fill(25, 77); model(4, 25);
        run_block(4, 25, 8'h00, "R6 loaded coefficients");

        // R7: invalid codes leave 2T=6 untouched.
        config_cycle(8'h82, 8'h00);
        config_cycle(8'h00, 8'h12);
        config_cycle(8'h22, 8'h34);
        config_cycle(8'h7F, 8'h56);
        config_cycle(8'h90, 8'h78);
        config_cycle(8'hFF, 8'h9A);
        fill(18, 5); make_gen(6, 1); model(6, 18);
        run_block(6, 18, 8'h00, "R7 invalid codes");

        // R8: codes driven while encoding are ignored.
        config_cycle(8'h84, 8'h00);
        fill(21, 9); make_gen(10, 1); model(10, 21);
        run_block(10, 21, 8'h8F, "R8 select code during encoding");
        fill(12, 10); model(10, 12);
        run_block(10, 12, 8'h02, "R8 write code during encoding");

        // R9: configuration cycle clears a half-encoded block and zeroes dout.
        config_cycle(8'h87, 8'h00);
        for (int i = 0; i < 5; i++) begin din = 8'(i * 29 + 3); step(); end
        config_cycle(8'h00, 8'hEE);
        check(dout == 8'h00, "R9", "dout after configuration", dout, 0);
        fill(14, 61); make_gen(16, 1); model(16, 14);
        run_block(16, 14, 8'h00, "R9 restart after clear");

        // R11: leading zeros (shortened code) do not change parity.
        fill(40, 33); model(16, 40);
        for (int i = 0; i < 51; i++) begin din = 8'h00; step(); end
        run_block(16, 40, 8'h00, "R11 leading zeros");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule